// File: doc/BRIEF.md
# External Interrupt Controller

This block gathers a configurable number of external interrupt request lines, up to 32, and merges them into a single interrupt request for the processor. Each line passes through a two-flop synchroniser. It can then be set to respond to a low level, a high level, a rising edge or a falling edge. Every line has an enable bit in a mask and a status flag. A line counts as pending when both are set, and any pending line raises the combined output.

Software reaches the block through a simple register bus with an address, write data, a write strobe, a read strobe and registered read data. Enable bits are changed through two separate registers: one sets bits for each 1 written and the other clears them. Configuration bits for lines that are not built read back as zero. Software can therefore write all ones to the sense-type register and find the line count from the highest bit that reads back as 1. A separate control bit sends the status of line 0 to a non-maskable interrupt output, and the mask does not apply on that path.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the following are all zero: mask, status, sense-type, edge-select and level-select registers, and the NMI enable. `irq_out` and `nmi_out` are low.
- R2: A write to byte offset 0x00 sets each mask bit whose write-data bit is 1 and leaves the others unchanged. The mask reads back at offset 0x08.
- R3: A write to byte offset 0x04 clears each mask bit whose write-data bit is 1 and leaves the others unchanged.
- R4: Status reads back at offset 0x0C. `irq_out` is high exactly when some line has both its status bit and its mask bit set.
- R5: A write to byte offset 0x10 clears the latched status of each edge-sensed line whose write-data bit is 1. Other lines are not affected.
- R6: The sense-type (0x14), edge-select (0x18) and level-select (0x1C) registers read back what was written in bits 0..NUM_LINES-1 and read zero above that.
- R7: With sense-type bit 0 (level) and level-select bit 0, a line sets its status while its input is low. This is the trigger in force after reset.
- R8: With sense-type bit 0 and level-select bit 1, a line sets its status while its input is high.
- R9: With sense-type bit 1 (edge) and edge-select bit 1, a rising input edge latches the status bit until it is cleared.
- R10: With sense-type bit 1 and edge-select bit 0, a falling input edge latches the status bit until it is cleared.
- R11: The status of a level-sensed line follows its synchronised input condition. A write to the clear register has no lasting effect on it.
- R12: Bit 0 at byte offset 0x24 enables the NMI path. `nmi_out` is high exactly when that bit and the status of line 0 are both set, whatever line 0's mask bit is.
- R13: An input change reaches a status bit on the third rising clock edge after it. Read data appears on `bus_rdata` after the rising edge at which `bus_re` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_lines | input | NUM_LINES | External interrupt inputs |
| irq_out | output | 1 | Combined interrupt request |
| nmi_out | output | 1 | Non-maskable interrupt request |

## Verification
The hardest situation to reach is a mix of trigger types across many lines while inputs keep toggling. In that mix, latched edge flags must survive later level changes, and partial acknowledges must clear only the chosen edge flags. The bench gives every line a random sense, edge and level setting. It then toggles random subsets of inputs and issues random clear writes and random mask set and clear writes. After each step it compares status, mask, `irq_out` and `nmi_out` with a model built from the trigger rules. Directed steps cover the three-edge latency, the NMI path with the mask at zero, and the line-count probe on a 20-line instance.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_we,
  input  logic                 bus_re,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_lines,
  output logic                 irq_out,
  output logic                 nmi_out
);
  localparam logic [ADDR_W-1:0] OFS_EN_SET = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_MASK   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_STAT   = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_ACK    = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_SENSE  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFS_EDGE   = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] OFS_LEVEL  = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] OFS_NMI    = ADDR_W'(8'h24);

  logic [NUM_LINES-1:0] sync1_q, sync2_q, prev_q;
  logic [NUM_LINES-1:0] mask_q, status_q, status_d;
  logic [NUM_LINES-1:0] sense_q, edge_q, level_q;
  logic                 nmi_en_q;
  logic [NUM_LINES-1:0] wd;
  logic [31:0]          rd_mux;

  assign wd = bus_wdata[NUM_LINES-1:0];

  wire wr_set   = bus_we && (bus_addr == OFS_EN_SET);
  wire wr_clr   = bus_we && (bus_addr == OFS_EN_CLR);
  wire wr_ack   = bus_we && (bus_addr == OFS_ACK);
  wire wr_sense = bus_we && (bus_addr == OFS_SENSE);
  wire wr_edge  = bus_we && (bus_addr == OFS_EDGE);
  wire wr_level = bus_we && (bus_addr == OFS_LEVEL);
  wire wr_nmi   = bus_we && (bus_addr == OFS_NMI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= irq_lines;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      sense_q  <= '0;
      edge_q   <= '0;
      level_q  <= '0;
      nmi_en_q <= 1'b0;
    end else begin
      if (wr_set)   mask_q   <= mask_q | wd;
      if (wr_clr)   mask_q   <= mask_q & ~wd;
      if (wr_sense) sense_q  <= wd;
      if (wr_edge)  edge_q   <= wd;
      if (wr_level) level_q  <= wd;
      if (wr_nmi)   nmi_en_q <= bus_wdata[0];
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic rise, fall, hit, ack;
    assign rise = sync2_q[i] & ~prev_q[i];
    assign fall = ~sync2_q[i] & prev_q[i];
    assign ack  = wr_ack & wd[i];
    assign hit  = sense_q[i] ? (edge_q[i] ? rise : fall)
                             : (sync2_q[i] == level_q[i]);
    assign status_d[i] = sense_q[i] ? (hit | (status_q[i] & ~ack)) : hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  always_comb begin
    case (bus_addr)
      OFS_MASK:  rd_mux = 32'(mask_q);
      OFS_STAT:  rd_mux = 32'(status_q);
      OFS_SENSE: rd_mux = 32'(sense_q);
      OFS_EDGE:  rd_mux = 32'(edge_q);
      OFS_LEVEL: rd_mux = 32'(level_q);
      OFS_NMI:   rd_mux = {31'd0, nmi_en_q};
      default:   rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= 32'd0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  assign irq_out = |(status_q & mask_q);
  assign nmi_out = nmi_en_q & status_q[0];
endmodule

module ext_irq_ctrl_chk #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic                 bus_we,
  input logic [NUM_LINES-1:0] mask,
  input logic                 nmi_en,
  input logic                 irq_out,
  input logic                 nmi_out
);
  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(8'h00)) |=>
      ((mask & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0])));

  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(8'h04)) |=>
      ((mask & $past(bus_wdata[NUM_LINES-1:0])) == '0));

  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == ADDR_W'(8'h00) || bus_addr == ADDR_W'(8'h04))) |=> $stable(mask));

  assert_no_irq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_out);

  assert_nmi_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_en |-> !nmi_out);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .mask(mask_q), .nmi_en(nmi_en_q),
  .irq_out(irq_out), .nmi_out(nmi_out)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  localparam int N = 20;
  localparam logic [31:0] IMPL = (32'd1 << N) - 32'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [N-1:0] lines = '1;
  logic irq_out, nmi_out;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ext_irq_ctrl #(.NUM_LINES(N), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .irq_lines(lines), .irq_out(irq_out), .nmi_out(nmi_out));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] level_exp(logic [31:0] sense, logic [31:0] lvl, logic [31:0] in);
    return ~sense & ~(in ^ lvl) & IMPL;
  endfunction

  function automatic logic [31:0] edge_events(logic [31:0] sense, logic [31:0] edg,
                                              logic [31:0] o, logic [31:0] n);
    return sense & ((edg & ~o & n) | (~edg & o & ~n)) & IMPL;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, m_exp, sense, edg, lvl, ev_st, old_in, new_in, ack, st_exp;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check("R1 irq_out", {31'd0, irq_out}, 32'd0);
    check("R1 nmi_out", {31'd0, nmi_out}, 32'd0);
    rst_n = 1'b1;
    rd(8'h08, d); check("R1 mask", d, 32'd0);
    rd(8'h14, d); check("R1 sense", d, 32'd0);
    rd(8'h24, d); check("R1 nmi en", d, 32'd0);
    repeat (4) @(negedge clk);
    rd(8'h0C, d); check("R1 status idle", d, 32'd0);

    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, d); check("R6 sense probe", d, IMPL);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, d); check("R6 edge probe", d, IMPL);
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, d); check("R6 level probe", d, IMPL);
    wr(8'h14, 0); wr(8'h18, 0); wr(8'h1C, 0);

    wr(8'h00, 32'h0000_00A5); rd(8'h08, d); check("R2 set", d, 32'h0000_00A5);
    wr(8'h00, 32'h0000_0100); rd(8'h08, d); check("R2 set keeps", d, 32'h0000_01A5);
    wr(8'h04, 32'h0000_0021); rd(8'h08, d); check("R3 clear", d, 32'h0000_0184);
    wr(8'h04, IMPL);          rd(8'h08, d); check("R3 clear all", d, 32'd0);

    @(negedge clk); lines[5] = 1'b0;
    repeat (4) @(negedge clk);
    rd(8'h0C, d); check("R7 level-low default", d, 32'h20);
    check("R4 masked off", {31'd0, irq_out}, 32'd0);
    wr(8'h00, 32'h20); check("R4 irq on", {31'd0, irq_out}, 32'd1);
    wr(8'h10, 32'h20); rd(8'h0C, d); check("R11 level ack no effect", d, 32'h20);
    @(negedge clk); lines[5] = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h0C, d); check("R11 level follows", d, 32'd0);
    wr(8'h04, IMPL);

    wr(8'h14, 32'h1); wr(8'h18, 32'h1); wr(8'h24, 32'h1);
    @(negedge clk); lines[0] = 1'b0;
    repeat (4) @(negedge clk);
    wr(8'h10, 32'h1);
    @(negedge clk); lines[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R13 two edges no nmi", {31'd0, nmi_out}, 32'd0);
    @(negedge clk);
    check("R13 third edge nmi", {31'd0, nmi_out}, 32'd1);
    check("R12 mask ignored irq", {31'd0, irq_out}, 32'd0);
    @(negedge clk); lines[0] = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 rising latched", {31'd0, nmi_out}, 32'd1);
    wr(8'h24, 32'h0);
    check("R12 nmi disabled", {31'd0, nmi_out}, 32'd0);
    wr(8'h10, 32'h1);

    sense = $urandom & IMPL; edg = $urandom & IMPL; lvl = $urandom & IMPL;
    wr(8'h14, sense); wr(8'h18, edg); wr(8'h1C, lvl); wr(8'h24, 32'h1);
    repeat (4) @(negedge clk);
    wr(8'h10, IMPL);
    ev_st = 0; m_exp = 0;
    for (int it = 0; it < 300; it++) begin
      int op = $urandom_range(0, 3);
      if (op == 0) begin
        d = $urandom & IMPL;
        if ($urandom_range(0, 1) == 1) begin wr(8'h00, d); m_exp = m_exp | d; end
        else begin wr(8'h04, d); m_exp = m_exp & ~d; end
        rd(8'h08, d); check("R2 R3 random mask", d, m_exp);
      end else if (op == 1) begin
        ack = $urandom & IMPL;
        wr(8'h10, ack);
        ev_st = ev_st & ~ack;
      end else begin
        old_in = 32'(lines);
        new_in = (old_in ^ ($urandom & $urandom)) & IMPL;
        @(negedge clk); lines = new_in[N-1:0];
        repeat (4) @(negedge clk);
        ev_st = ev_st | edge_events(sense, edg, old_in, new_in);
      end
      st_exp = level_exp(sense, lvl, 32'(lines)) | ev_st;
      rd(8'h0C, d); check("R5 R8 R9 R10 R11 random status", d, st_exp);
      check("R4 random irq", {31'd0, irq_out}, {31'd0, |(st_exp & m_exp)});
      check("R12 random nmi", {31'd0, nmi_out}, {31'd0, st_exp[0]});
    end

    wr(8'h14, 32'h3); wr(8'h18, 32'h0); wr(8'h1C, 32'h4);
    @(negedge clk); lines[2:0] = 3'b111;
    repeat (4) @(negedge clk);
    wr(8'h10, 32'h3);
    @(negedge clk); lines[2:0] = 3'b000;
    repeat (4) @(negedge clk);
    rd(8'h0C, d); check("R10 falling both", d & 32'h7, 32'h3);
    wr(8'h10, 32'h2); rd(8'h0C, d); check("R5 ack one line only", d & 32'h7, 32'h1);
    @(negedge clk); lines[2] = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h0C, d); check("R8 level-high", d & 32'h7, 32'h5);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule